// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is an I2C target that lets an external bus master reach a 256-entry byte register file. Bus lines are oversampled on the system clock, so the block needs no clock derived from SCL. The block decodes START, repeated START and STOP, matches a 7-bit device address and answers with ACK or NACK. It pulls SDA low through a single open-drain enable output.

Every write transfer carries three kinds of byte in a fixed order. The command byte comes first, and its two low bits must be zero. The register address comes next. Any number of data bytes follow, each stored at the next address. A transfer that ends after the address byte only moves the pointer.

Every read transfer returns a fixed identification byte first. It then streams register contents from the pointer, which advances with each byte sent. The pointer is shared by reads and writes, so a read with no preceding address resumes at the register after the last one touched. A master can also follow the address byte with a repeated START and go straight into a read.

Top module: `i2cRegSlave`

## Requirements
- R1: After reset SDA is released, the register pointer is 0x00 and every register holds 0x00.
- R2: The slave ACKs an address byte whose upper seven bits equal the device address (bit 0 is R/W, 1 = read). On a mismatch it NACKs and keeps SDA released until the next START or STOP.
- R3: The command byte is ACKed when its bits [1:0] are 00, whatever its upper six bits hold. Otherwise it is NACKed, and every later byte of that transfer is NACKed and stores nothing.
- R4: In a write, the register address byte is ACKed and loads the pointer. Each data byte is ACKed, stored at the pointer, and advances the pointer by one.
- R5: A read transfer returns the ID byte 0x10 first. It then returns register contents starting at the pointer, and the pointer advances by one per data byte sent.
- R6: A read with no address set resumes at the register after the last one read or written. A write transfer that stops after the address byte sets where the next read starts.
- R7: A repeated START with a read address, issued right after the register address ACK, begins a read transfer at that register.
- R8: The pointer wraps from 0xFF to 0x00, in writes and in reads alike.
- R9: After the master NACKs a read byte, the slave keeps SDA released until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When high, the pad pulls SDA low |

## Verification
The assertions assume the master changes SDA only while SCL is low, except when it makes a START or STOP. They also assume each SCL level lasts several system clocks, longer than the synchronizer delay. The bench drives the bus with the same quarter-period on every edge, and that period is well above the synchronizer delay. It also releases SDA whenever the slave is meant to drive it, so the wired-AND line seen by both sides stays legal. A NACK ends a read only when the master is not holding SDA low, and the bench never holds it low there.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  typedef struct packed {
    logic rxShift;
    logic loadId;
    logic loadReg;
    logic txShift;
    logic setPtr;
    logic writeReg;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_IGNORE
  } ctrlState_t;

endpackage

// File: rtl/i2cRegFile.sv
module i2cRegFile #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/i2cRegData.sv
module i2cRegData
  import i2cRegPkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] ID_BYTE = 8'h10
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t stb,
  input  logic      rxBitVal,
  output logic [7:0] rxByte,
  output logic      txBit
);
  logic [7:0]        rxReg;
  logic [7:0]        txReg;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        rdData;

  i2cRegFile #(.ADDR_W(ADDR_W), .DATA_W(8)) u_regFile (
    .clk   (clk),
    .rstN  (rstN),
    .we    (stb.writeReg),
    .addr  (ptr),
    .wdata (rxReg),
    .rdata (rdData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg <= '0;
      txReg <= '0;
      ptr   <= '0;
    end else begin
      if (stb.rxShift) rxReg <= {rxReg[6:0], rxBitVal};
      if (stb.loadId) txReg <= ID_BYTE;
      else if (stb.loadReg) txReg <= rdData;
      else if (stb.txShift) txReg <= {txReg[6:0], 1'b0};
      if (stb.setPtr) ptr <= rxReg[ADDR_W-1:0];
      else if (stb.writeReg || stb.loadReg) ptr <= ptr + 1'b1;
    end
  end

  assign rxByte = rxReg;
  assign txBit  = txReg[7];

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeReg |=> ptr == $past(ptr) + 1'b1);
  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.writeReg || stb.loadReg) && !stb.setPtr && ptr == '1) |=> ptr == '0);
  // R5
  id_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadId |=> txReg == ID_BYTE);
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.setPtr || stb.writeReg || stb.loadReg) |=> $stable(ptr));

endmodule

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrobe_t  stb,
  output logic       rxBitVal,
  output logic       sdaOe
);
  logic [2:0] sclSync, sdaSync;
  logic sclNow, sclOld, sdaNow, sdaOld;
  logic sclRise, sclFall, startDet, stopDet;

  ctrlState_t state, stateNxt;
  logic [3:0] bitCnt, bitCntNxt;
  logic ackDrive, ackNxt, rwBit, rwNxt, masterNack, nackNxt;
  logic isRx, byteDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
    end else begin
      sclSync <= {sclSync[1:0], sclIn};
      sdaSync <= {sdaSync[1:0], sdaIn};
    end
  end

  assign sclNow   = sclSync[1];
  assign sclOld   = sclSync[2];
  assign sdaNow   = sdaSync[1];
  assign sdaOld   = sdaSync[2];
  assign sclRise  = sclNow && !sclOld;
  assign sclFall  = !sclNow && sclOld;
  assign startDet = sclNow && sclOld && sdaOld && !sdaNow;
  assign stopDet  = sclNow && sclOld && !sdaOld && sdaNow;
  assign rxBitVal = sdaNow;

  assign isRx = (state == ST_ADDR) || (state == ST_CMD) ||
                (state == ST_REG)  || (state == ST_WDATA);
  assign byteDone = sclFall && (bitCnt == 4'd8);

  always_comb begin
    stateNxt  = state;
    bitCntNxt = bitCnt;
    ackNxt    = ackDrive;
    rwNxt     = rwBit;
    nackNxt   = masterNack;
    stb       = '0;
    if (startDet) begin
      stateNxt  = ST_ADDR;
      bitCntNxt = '0;
      ackNxt    = 1'b0;
    end else if (stopDet) begin
      stateNxt = ST_IDLE;
      ackNxt   = 1'b0;
    end else begin
      if (isRx && sclRise && bitCnt < 4'd8) begin
        stb.rxShift = 1'b1;
        bitCntNxt   = bitCnt + 4'd1;
      end
      case (state)
        ST_ADDR: if (byteDone) begin
          bitCntNxt = '0;
          if (rxByte[7:1] == DEV_ADDR) begin
            rwNxt    = rxByte[0];
            ackNxt   = 1'b1;
            stateNxt = ST_ADDR_ACK;
          end else begin
            stateNxt = ST_IGNORE;
          end
        end
        ST_CMD: if (byteDone) begin
          bitCntNxt = '0;
          if (rxByte[1:0] == 2'b00) begin
            ackNxt   = 1'b1;
            stateNxt = ST_CMD_ACK;
          end else begin
            stateNxt = ST_IGNORE;
          end
        end
        ST_REG: if (byteDone) begin
          bitCntNxt  = '0;
          stb.setPtr = 1'b1;
          ackNxt     = 1'b1;
          stateNxt   = ST_REG_ACK;
        end
        ST_WDATA: if (byteDone) begin
          bitCntNxt    = '0;
          stb.writeReg = 1'b1;
          ackNxt       = 1'b1;
          stateNxt     = ST_WDATA_ACK;
        end
        ST_ADDR_ACK: if (sclFall) begin
          ackNxt = 1'b0;
          if (rwBit) begin
            stb.loadId = 1'b1;
            stateNxt   = ST_TX;
          end else begin
            stateNxt = ST_CMD;
          end
        end
        ST_CMD_ACK: if (sclFall) begin
          ackNxt   = 1'b0;
          stateNxt = ST_REG;
        end
        ST_REG_ACK, ST_WDATA_ACK: if (sclFall) begin
          ackNxt   = 1'b0;
          stateNxt = ST_WDATA;
        end
        ST_TX: if (sclFall) begin
          if (bitCnt == 4'd7) begin
            bitCntNxt = '0;
            stateNxt  = ST_TX_ACK;
          end else begin
            stb.txShift = 1'b1;
            bitCntNxt   = bitCnt + 4'd1;
          end
        end
        ST_TX_ACK: begin
          if (sclRise) nackNxt = sdaNow;
          if (sclFall) begin
            if (!masterNack) begin
              stb.loadReg = 1'b1;
              stateNxt    = ST_TX;
            end else begin
              stateNxt = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      ackDrive   <= 1'b0;
      rwBit      <= 1'b0;
      masterNack <= 1'b0;
    end else begin
      state      <= stateNxt;
      bitCnt     <= bitCntNxt;
      ackDrive   <= ackNxt;
      rwBit      <= rwNxt;
      masterNack <= nackNxt;
    end
  end

  assign sdaOe = ackDrive || (state == ST_TX && !txBit);

  // R2
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclNow);
  // R9
  ignore_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> !sdaOe);
  // R7
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == 4'd0));
  // R3
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD && byteDone && !startDet && !stopDet && rxByte[1:0] != 2'b00)
      |=> (state == ST_IGNORE && !sdaOe));

endmodule

// File: rtl/i2cRegSlave.sv
module i2cRegSlave
  import i2cRegPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter logic [7:0] ID_BYTE  = 8'h10,
  parameter int         ADDR_W   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);
  dpStrobe_t  stb;
  logic       rxBitVal;
  logic [7:0] rxByte;
  logic       txBit;

  i2cRegCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .rxByte   (rxByte),
    .txBit    (txBit),
    .stb      (stb),
    .rxBitVal (rxBitVal),
    .sdaOe    (sdaOe)
  );

  i2cRegData #(.ADDR_W(ADDR_W), .ID_BYTE(ID_BYTE)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rxBitVal (rxBitVal),
    .rxByte   (rxByte),
    .txBit    (txBit)
  );

endmodule

// File: tb/i2cRegSlave_bench.sv
module i2cRegSlave_bench;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;
  int nVec = 0;
  int nBad = 0;
  bit finished = 1'b0;
  logic [7:0] model [256];

  always #2.5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;

  i2cRegSlave u_i2cRegSlave (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclM),
    .sdaIn (sdaLine),
    .sdaOe (sdaOe)
  );

  function automatic logic [7:0] val(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBit(input bit b);
    sdaM = b; waitQ(); sclM = 1'b1; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic readBit(output bit b);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    b = sdaLine; sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    readBit(a);
    ack = !a;
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      d[i] = b;
    end
    sendBit(nack);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    bit a;
    bit b;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1: line released after reset
    chk(sdaLine == 1'b1, "R1 idle", sdaLine, 1);

    // R5 / R1: ID then reset contents
    busStart();
    sendByte({DEV, 1'b1}, a); chk(a, "R2 read addr ack", a, 1);
    recvByte(1'b0, d); chk(d == 8'h10, "R5 id", d, 8'h10);
    recvByte(1'b0, d); chk(d == 8'h00, "R1 reg0", d, 0);
    recvByte(1'b1, d); chk(d == 8'h00, "R1 reg1", d, 0);
    busStop();

    // R2: mismatched address, write and read
    busStart();
    sendByte({DEV ^ 7'h01, 1'b0}, a); chk(!a, "R2 nack", a, 0);
    sendByte(8'h00, a); chk(!a, "R2 released", a, 0);
    sendByte(8'h55, a); chk(!a, "R2 released", a, 0);
    busStop();
    busStart();
    sendByte({DEV ^ 7'h40, 1'b1}, a); chk(!a, "R2 nack rd", a, 0);
    readBit(b); chk(b, "R2 no drive", b, 1);
    busStop();

    // R4 / R8: write all registers from 0, wrapping back to 0
    busStart();
    sendByte({DEV, 1'b0}, a); chk(a, "R2 ack", a, 1);
    sendByte(8'hA4, a); chk(a, "R3 cmd ack", a, 1);
    sendByte(8'h00, a); chk(a, "R4 reg ack", a, 1);
    for (int i = 0; i < 256; i++) begin
      sendByte(val(i), a); chk(a, "R4 data ack", a, 1);
      model[i] = val(i);
    end
    busStop();

    // R3: bad command codes block writes
    busStart();
    sendByte({DEV, 1'b0}, a); chk(a, "R2 ack", a, 1);
    sendByte(8'h11, a); chk(!a, "R3 bad cmd", a, 0);
    sendByte(8'h10, a); chk(!a, "R3 ignored reg", a, 0);
    sendByte(8'hEE, a); chk(!a, "R3 ignored data", a, 0);
    busStop();
    busStart();
    sendByte({DEV, 1'b0}, a);
    sendByte(8'h02, a); chk(!a, "R3 bad cmd 10", a, 0);
    sendByte(8'h11, a); chk(!a, "R3 ignored reg", a, 0);
    sendByte(8'hEE, a); chk(!a, "R3 ignored data", a, 0);
    busStop();

    // R7 / R8: address then repeated START read across the wrap
    busStart();
    sendByte({DEV, 1'b0}, a);
    sendByte(8'hFC, a); chk(a, "R3 upper bits ignored", a, 1);
    sendByte(8'hFE, a); chk(a, "R4 reg ack", a, 1);
    busStart();
    sendByte({DEV, 1'b1}, a); chk(a, "R7 restart ack", a, 1);
    recvByte(1'b0, d); chk(d == 8'h10, "R7 id", d, 8'h10);
    for (int i = 0; i < 4; i++) begin
      recvByte(i == 3, d);
      chk(d == model[(254 + i) % 256], "R8 wrap read", d, model[(254 + i) % 256]);
    end
    // R9: line released after master NACK
    readBit(b); chk(b, "R9 released", b, 1);
    busStop();

    // R6: implicit pointer continues after last read (0x02)
    busStart();
    sendByte({DEV, 1'b1}, a);
    recvByte(1'b0, d); chk(d == 8'h10, "R5 id", d, 8'h10);
    recvByte(1'b1, d); chk(d == model[2], "R6 after read", d, model[2]);
    busStop();

    // R6: continue after a write
    busStart();
    sendByte({DEV, 1'b0}, a);
    sendByte(8'h00, a);
    sendByte(8'h80, a);
    sendByte(8'h5A, a); chk(a, "R4 data ack", a, 1);
    sendByte(8'hA5, a); chk(a, "R4 data ack", a, 1);
    busStop();
    model[128] = 8'h5A;
    model[129] = 8'hA5;
    busStart();
    sendByte({DEV, 1'b1}, a);
    recvByte(1'b0, d); chk(d == 8'h10, "R5 id", d, 8'h10);
    recvByte(1'b1, d); chk(d == model[130], "R6 after write", d, model[130]);
    busStop();

    // R6 / R5: address-only write then full read sweep
    busStart();
    sendByte({DEV, 1'b0}, a);
    sendByte(8'h00, a);
    sendByte(8'h00, a); chk(a, "R6 addr only", a, 1);
    busStop();
    busStart();
    sendByte({DEV, 1'b1}, a);
    recvByte(1'b0, d); chk(d == 8'h10, "R5 id", d, 8'h10);
    for (int i = 0; i < 256; i++) begin
      recvByte(i == 255, d);
      chk(d == model[i], "R5 sweep", d, model[i]);
    end
    busStop();

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule